// File: doc/BRIEF.md
# Card command response status unit

The unit takes a 16-bit command word from the host, hands the command index and a 32-bit argument to the card side, and waits for the card's reply. The card side returns up to sixteen response bytes at once, with a byte count. When the reply arrives, the unit checks the byte count against what the response type needs. It then applies the type's own error rule, packs the bytes into eight 16-bit response registers and updates a 16-bit status register.

The host builds the argument from two 16-bit halves. It clears status bits by writing ones to them and gates the interrupt with a 16-bit enable mask. A command whose command-type field selects an addressed data transfer resets the data FIFO pointers and marks a transfer active with the latched direction. The data path itself, CRC handling and the serial card protocol are outside this unit.

Response byte k sits at `card_rsp_data_i[8k+7:8k]`, and response register j sits at `rsp_o[16j+15:16j]`.

Top module: `cmd_rsp_unit`

## Requirements
- R1: A command write (`cmd_we_i`) is accepted only when `enable_i` is 1 and no command is outstanding. An ignored write leaves `last_cmd_o` unchanged and raises no `card_req_o`. An accepted write stores the word in `last_cmd_o`. Command word fields: index = bits 5:0, response type = bits 10:8, busy flag = bit 11, command type = bits 13:12, direction = bit 15.
- R2: One cycle after acceptance, `card_req_o` is high for exactly one cycle. At the same time `card_idx_o` carries the index, all eight response registers read zero, and `cmd_pending_o` stays high until a `card_rsp_valid_i` cycle completes the command.
- R3: `card_arg_o` holds the argument. `arg_lo_we_i` loads bits 15:0 from `arg_half_i`, `arg_hi_we_i` loads bits 31:16, and each leaves the other half unchanged.
- R4: Response types 1, 3 and 6 need at least 4 bytes and type 2 needs 16. A shorter reply is a timeout: status bit 7 is set and no response is stored. Types 4, 5 and 7 apply no length check and no error test.
- R5: For type 1, bytes 0..3 form a big-endian word (byte 0 most significant), tested against mask 0xFDF90000. Bit 3 is added to that mask only while `auth_chk_en_i` is 1. The busy flag does not change this rule.
- R6: For type 3, if bit 31 of the big-endian word is set, status is ANDed with 0xE000. Otherwise status bit 12 is set. No error test follows, so the clean-case rule of R7 applies.
- R7: For type 6, the 16-bit value {byte 2, byte 3} is tested against 0xE008. For every type, a hit sets status bit 14; no hit ANDs status with 0xB000.
- R8: A stored reply fills register 7-i with {byte 2i, byte 2i+1} for i = 0..7. Type 0 and zero-length replies store nothing, so the registers stay zero.
- R9: If there is no timeout, completion sets status bit 0, and also bit 2 when the index is 12. These bits are applied after the R4 to R7 updates.
- R10: An accepted command with command type 3 pulses `fifo_rst_o`, sets `xfer_active_o` and latches bit 15 into `xfer_dir_o`. Any other command type clears `xfer_active_o`.
- R11: `stat_clr_we_i` clears every status bit set in `stat_clr_i`. In a completion cycle the clear is applied first.
- R12: `irq_o` is 1 exactly when status ANDed with `irq_mask_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enable; command writes ignored when 0 |
| auth_chk_en_i | input | 1 | Adds bit 3 to the type-1 error mask |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 16 | Command word |
| arg_lo_we_i | input | 1 | Load argument bits 15:0 |
| arg_hi_we_i | input | 1 | Load argument bits 31:16 |
| arg_half_i | input | 16 | Argument half value |
| stat_clr_we_i | input | 1 | Status write-one-to-clear strobe |
| stat_clr_i | input | 16 | Status bits to clear |
| irq_mask_i | input | 16 | Interrupt enable mask |
| card_req_o | output | 1 | One-cycle command issue pulse to the card side |
| card_idx_o | output | 6 | Command index of the outstanding command |
| card_arg_o | output | 32 | Command argument |
| card_rsp_valid_i | input | 1 | Card reply present |
| card_rsp_len_i | input | LEN_W | Reply byte count |
| card_rsp_data_i | input | 16*RSP_WORDS | Reply bytes, byte k at bits 8k+7:8k |
| cmd_pending_o | output | 1 | Command outstanding |
| last_cmd_o | output | 16 | Last accepted command word |
| rsp_o | output | 16*RSP_WORDS | Response registers, register j at bits 16j+15:16j |
| status_o | output | 16 | Status register |
| irq_o | output | 1 | Interrupt request |
| xfer_active_o | output | 1 | Data transfer active |
| xfer_dir_o | output | 1 | Latched transfer direction |
| fifo_rst_o | output | 1 | One-cycle FIFO pointer reset pulse |

## Verification
On every cycle, the assertions check the following: a disabled write is dropped, the issue pulse lasts one cycle with the response bank already cleared, a short type-2 reply raises the timeout bit, a data-transfer command starts a transfer, and the write-one-to-clear takes effect. The exact status value after each response rule is covered only by the bench scenarios. This includes the order of the type-3 adjustment, the error test and the completion bits, and the conditional authentication bit. The same holds for the reversed word packing, the drop of a command written while one is outstanding, and the interrupt under changing masks.

// File: rtl/cmd_rsp_pkg.sv
package cmd_rsp_pkg;
  localparam logic [2:0]  RT_NONE  = 3'd0;
  localparam logic [2:0]  RT_SHORT = 3'd1;
  localparam logic [2:0]  RT_LONG  = 3'd2;
  localparam logic [2:0]  RT_OCR   = 3'd3;
  localparam logic [2:0]  RT_ADDR  = 3'd6;
  localparam logic [1:0]  CT_DATA  = 2'd3;
  localparam logic [5:0]  IDX_STOP = 6'd12;
  localparam int unsigned SHORT_LEN = 4;

  localparam logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000;
  localparam logic [31:0] AUTH_SEQ_BIT  = 32'h0000_0008;
  localparam logic [31:0] ADDR_ERR_MASK = 32'h0000_E000;
  localparam logic [15:0] KEEP_CLEAN    = 16'hB000;
  localparam logic [15:0] KEEP_OCR_BUSY = 16'hE000;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_STOP = 2;
  localparam int unsigned ST_TMO  = 7;
  localparam int unsigned ST_OCR  = 12;
  localparam int unsigned ST_ERR  = 14;
endpackage

// File: rtl/rsp_eval.sv
module rsp_eval
  import cmd_rsp_pkg::*;
#(
  parameter int unsigned RSP_WORDS = 8,
  parameter int unsigned LEN_W     = 5
) (
  input  logic [15:0]      status_i,
  input  logic [2:0]       rtype_i,
  input  logic [5:0]       idx_i,
  input  logic             auth_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      head_i,
  output logic [15:0]      status_o,
  output logic             store_o
);
  localparam int unsigned LONG_LEN = 2 * RSP_WORDS;

  logic [31:0] be_word, test_word, test_mask;
  logic        short_ok, long_ok, tmo;
  logic [15:0] s;

  assign be_word  = {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]};
  assign short_ok = len_i >= LEN_W'(SHORT_LEN);
  assign long_ok  = len_i >= LEN_W'(LONG_LEN);

  always_comb begin
    s         = status_i;
    tmo       = 1'b0;
    test_word = '0;
    test_mask = '0;
    case (rtype_i)
      RT_SHORT: begin
        if (!short_ok) tmo = 1'b1;
        else begin
          test_word = be_word;
          test_mask = CARD_ERR_MASK | (auth_i ? AUTH_SEQ_BIT : 32'h0);
        end
      end
      RT_LONG: tmo = !long_ok;
      RT_OCR: begin
        if (!short_ok) tmo = 1'b1;
        else if (be_word[31]) s = s & KEEP_OCR_BUSY;
        else s[ST_OCR] = 1'b1;
      end
      RT_ADDR: begin
        if (!short_ok) tmo = 1'b1;
        else begin
          test_word = {16'h0, be_word[15:0]};
          test_mask = ADDR_ERR_MASK | AUTH_SEQ_BIT;
        end
      end
      default: ;
    endcase
    if (|(test_word & test_mask)) s[ST_ERR] = 1'b1;
    else s = s & KEEP_CLEAN;
    if (tmo) s[ST_TMO] = 1'b1;
    else begin
      s[ST_DONE] = 1'b1;
      if (idx_i == IDX_STOP) s[ST_STOP] = 1'b1;
    end
  end

  assign status_o = s;
  assign store_o  = !tmo && (rtype_i != RT_NONE) && (len_i != '0);
endmodule

// File: rtl/rsp_bank.sv
module rsp_bank #(
  parameter int unsigned RSP_WORDS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [16*RSP_WORDS-1:0]  bytes_i,
  output logic [16*RSP_WORDS-1:0]  rsp_o
);
  localparam int unsigned NBYTES = 2 * RSP_WORDS;

  logic [15:0] words_q [RSP_WORDS];

  for (genvar j = 0; j < RSP_WORDS; j++) begin : g_word
    // word j takes the byte pair counted from the far end
    localparam int unsigned HI = NBYTES - 2 - 2 * j;
    localparam int unsigned LO = NBYTES - 1 - 2 * j;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     words_q[j] <= '0;
      else if (clr_i)  words_q[j] <= '0;
      else if (load_i) words_q[j] <= {bytes_i[8*HI +: 8], bytes_i[8*LO +: 8]};
    end
    assign rsp_o[16*j +: 16] = words_q[j];
  end
endmodule

// File: rtl/stat_reg.sv
module stat_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_we_i,
  input  logic [15:0] clr_i,
  input  logic        upd_i,
  input  logic [15:0] upd_val_i,
  input  logic [15:0] mask_i,
  output logic [15:0] base_o,
  output logic [15:0] status_o,
  output logic        irq_o
);
  logic [15:0] status_q;

  assign base_o = clr_we_i ? (status_q & ~clr_i) : status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= '0;
    else if (upd_i) status_q <= upd_val_i;
    else            status_q <= base_o;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_i);

  // R11
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && !upd_i |=> (status_o & $past(clr_i)) == 16'h0);
endmodule

// File: rtl/cmd_rsp_unit.sv
module cmd_rsp_unit
  import cmd_rsp_pkg::*;
#(
  parameter int unsigned RSP_WORDS = 8,
  parameter int unsigned LEN_W     = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    auth_chk_en_i,
  input  logic                    cmd_we_i,
  input  logic [15:0]             cmd_word_i,
  input  logic                    arg_lo_we_i,
  input  logic                    arg_hi_we_i,
  input  logic [15:0]             arg_half_i,
  input  logic                    stat_clr_we_i,
  input  logic [15:0]             stat_clr_i,
  input  logic [15:0]             irq_mask_i,
  output logic                    card_req_o,
  output logic [5:0]              card_idx_o,
  output logic [31:0]             card_arg_o,
  input  logic                    card_rsp_valid_i,
  input  logic [LEN_W-1:0]        card_rsp_len_i,
  input  logic [16*RSP_WORDS-1:0] card_rsp_data_i,
  output logic                    cmd_pending_o,
  output logic [15:0]             last_cmd_o,
  output logic [16*RSP_WORDS-1:0] rsp_o,
  output logic [15:0]             status_o,
  output logic                    irq_o,
  output logic                    xfer_active_o,
  output logic                    xfer_dir_o,
  output logic                    fifo_rst_o
);
  logic        pending_q, req_q, fifo_rst_q, xfer_q, dir_q;
  logic [15:0] last_cmd_q;
  logic [31:0] arg_q;
  logic [5:0]  idx_q;
  logic [2:0]  rtype_q;
  logic        cmd_accept, rsp_done, is_data;
  logic [15:0] stat_base, stat_next;
  logic        store;

  assign cmd_accept = cmd_we_i && enable_i && !pending_q;
  assign rsp_done   = pending_q && card_rsp_valid_i;
  assign is_data    = cmd_word_i[13:12] == CT_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q  <= 1'b0;
      req_q      <= 1'b0;
      fifo_rst_q <= 1'b0;
      xfer_q     <= 1'b0;
      dir_q      <= 1'b0;
      last_cmd_q <= '0;
      idx_q      <= '0;
      rtype_q    <= '0;
    end else begin
      req_q      <= cmd_accept;
      fifo_rst_q <= cmd_accept && is_data;
      if (cmd_accept) begin
        pending_q  <= 1'b1;
        last_cmd_q <= cmd_word_i;
        idx_q      <= cmd_word_i[5:0];
        rtype_q    <= cmd_word_i[10:8];
        xfer_q     <= is_data;
        if (is_data) dir_q <= cmd_word_i[15];
      end else if (rsp_done) begin
        pending_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arg_q <= '0;
    else begin
      if (arg_lo_we_i) arg_q[15:0]  <= arg_half_i;
      if (arg_hi_we_i) arg_q[31:16] <= arg_half_i;
    end
  end

  rsp_eval #(.RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)) i_rsp_eval (
    .status_i (stat_base),
    .rtype_i  (rtype_q),
    .idx_i    (idx_q),
    .auth_i   (auth_chk_en_i),
    .len_i    (card_rsp_len_i),
    .head_i   (card_rsp_data_i[31:0]),
    .status_o (stat_next),
    .store_o  (store)
  );

  stat_reg i_stat_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_we_i  (stat_clr_we_i),
    .clr_i     (stat_clr_i),
    .upd_i     (rsp_done),
    .upd_val_i (stat_next),
    .mask_i    (irq_mask_i),
    .base_o    (stat_base),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  rsp_bank #(.RSP_WORDS(RSP_WORDS)) i_rsp_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cmd_accept),
    .load_i  (rsp_done && store),
    .bytes_i (card_rsp_data_i),
    .rsp_o   (rsp_o)
  );

  assign card_req_o    = req_q;
  assign card_idx_o    = idx_q;
  assign card_arg_o    = arg_q;
  assign cmd_pending_o = pending_q;
  assign last_cmd_o    = last_cmd_q;
  assign xfer_active_o = xfer_q;
  assign xfer_dir_o    = dir_q;
  assign fifo_rst_o    = fifo_rst_q;

  // R1
  disabled_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !enable_i |=> !card_req_o && $stable(last_cmd_o));
  // R2
  issue_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |-> (rsp_o == '0) && cmd_pending_o);
  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |=> !card_req_o);
  // R4
  long_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pending_o && card_rsp_valid_i && rtype_q == RT_LONG &&
    card_rsp_len_i < LEN_W'(2 * RSP_WORDS) |=> status_o[ST_TMO] && rsp_o == '0);
  // R10
  xfer_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_accept && cmd_word_i[13:12] == CT_DATA |=> xfer_active_o && fifo_rst_o
      && xfer_dir_o == $past(cmd_word_i[15]));
endmodule

// File: tb/test_cmd_rsp_unit.sv
`timescale 1ns/1ps
module test_cmd_rsp_unit;
  localparam int unsigned RW = 8;
  localparam int unsigned LW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, auth_chk_en_i = 1'b0, cmd_we_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic arg_lo_we_i = 1'b0, arg_hi_we_i = 1'b0;
  logic [15:0] arg_half_i = '0;
  logic stat_clr_we_i = 1'b0;
  logic [15:0] stat_clr_i = '0, irq_mask_i = '0;
  logic card_req_o;
  logic [5:0] card_idx_o;
  logic [31:0] card_arg_o;
  logic card_rsp_valid_i = 1'b0;
  logic [LW-1:0] card_rsp_len_i = '0;
  logic [16*RW-1:0] card_rsp_data_i = '0;
  logic cmd_pending_o;
  logic [15:0] last_cmd_o;
  logic [16*RW-1:0] rsp_o;
  logic [15:0] status_o;
  logic irq_o, xfer_active_o, xfer_dir_o, fifo_rst_o;

  cmd_rsp_unit #(.RSP_WORDS(RW), .LEN_W(LW)) i_cmd_rsp_unit (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic [15:0] e_status = '0;
  logic [31:0] e_arg = '0;
  logic [15:0] e_last = '0;
  logic        e_xfer = 1'b0, e_dir = 1'b0;
  logic [127:0] e_rsp = '0;
  logic [15:0] cur_w = '0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [127:0] d, input int k);
    return d[8*k +: 8];
  endfunction

  // Expected status after a reply, from R4..R9
  function automatic logic [15:0] exp_stat(input logic [15:0] st, input logic [15:0] w,
      input logic [4:0] len, input logic [127:0] d, input logic auth, output logic stored);
    logic [2:0] rt = w[10:8];
    logic [31:0] cs = {byte_at(d,0), byte_at(d,1), byte_at(d,2), byte_at(d,3)};
    logic hit = 1'b0, late = 1'b0;
    int need = 0;
    if (rt == 3'd1 || rt == 3'd3 || rt == 3'd6) need = 4;
    if (rt == 3'd2) need = 16;
    late = (need != 0) && (int'(len) < need);
    if (!late) begin
      if (rt == 3'd1) hit = ((cs & 32'hFDF90000) != 0) || (auth && cs[3]);
      if (rt == 3'd6) hit = ((cs[15:0] & 16'hE008) != 0);
      if (rt == 3'd3) begin
        if (cs[31]) st = st & 16'hE000;
        else st[12] = 1'b1;
      end
    end
    if (hit) st[14] = 1'b1;
    else st = st & 16'hB000;
    if (late) st[7] = 1'b1;
    else begin
      st[0] = 1'b1;
      if (w[5:0] == 6'd12) st[2] = 1'b1;
    end
    stored = !late && rt != 3'd0 && len != 0;
    return st;
  endfunction

  function automatic logic [127:0] exp_bank(input logic [127:0] d);
    logic [127:0] r = '0;
    for (int i = 0; i < 8; i++) r[16*(7-i) +: 16] = {byte_at(d, 2*i), byte_at(d, 2*i+1)};
    return r;
  endfunction

  function automatic string rule_tag(input logic [15:0] w);
    case (w[10:8])
      3'd1: return "R5";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic issue(input logic [15:0] w, input logic auth);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_word_i = w; auth_chk_en_i = auth;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    cur_w = w; e_last = w;
    chk("R2 req pulse", card_req_o, 1'b1);
    chk("R2 index", card_idx_o, w[5:0]);
    chk("R3 arg at issue", card_arg_o, e_arg);
    chk("R2 bank cleared", rsp_o, '0);
    chk("R1 last cmd", last_cmd_o, w);
    if (w[13:12] == 2'd3) begin e_xfer = 1'b1; e_dir = w[15]; end
    else e_xfer = 1'b0;
    chk("R10 fifo reset", fifo_rst_o, w[13:12] == 2'd3);
    chk("R10 xfer active", xfer_active_o, e_xfer);
    chk("R10 xfer dir", xfer_dir_o, e_dir);
  endtask

  task automatic respond(input logic [4:0] len, input logic [127:0] d);
    logic st;
    string tg;
    @(negedge clk_i);
    card_rsp_valid_i = 1'b1; card_rsp_len_i = len; card_rsp_data_i = d;
    chk("R2 pulse ends", card_req_o, 1'b0);
    @(negedge clk_i);
    card_rsp_valid_i = 1'b0;
    e_status = exp_stat(e_status, cur_w, len, d, auth_chk_en_i, st);
    e_rsp = st ? exp_bank(d) : '0;
    tg = rule_tag(cur_w);
    chk({tg, " status"}, status_o, e_status);
    chk("R8 bank", rsp_o, e_rsp);
    chk("R12 irq", irq_o, |(e_status & irq_mask_i));
    chk("R2 pending cleared", cmd_pending_o, 1'b0);
  endtask

  task automatic clear_stat(input logic [15:0] v);
    @(negedge clk_i);
    stat_clr_we_i = 1'b1; stat_clr_i = v;
    @(negedge clk_i);
    stat_clr_we_i = 1'b0;
    e_status &= ~v;
    chk("R11 w1c", status_o, e_status);
    chk("R12 irq after clear", irq_o, |(e_status & irq_mask_i));
  endtask

  task automatic set_arg(input logic hi, input logic [15:0] v);
    @(negedge clk_i);
    arg_half_i = v; arg_lo_we_i = !hi; arg_hi_we_i = hi;
    @(negedge clk_i);
    arg_lo_we_i = 1'b0; arg_hi_we_i = 1'b0;
    if (hi) e_arg[31:16] = v; else e_arg[15:0] = v;
    chk("R3 arg half", card_arg_o, e_arg);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk("R2 reset status", status_o, 16'h0);
    chk("R8 reset bank", rsp_o, '0);
    chk("R2 reset req", card_req_o, 1'b0);
    chk("R1 reset last", last_cmd_o, 16'h0);
    chk("R12 reset irq", irq_o, 1'b0);
    rst_ni = 1'b1;

    set_arg(1'b0, 16'h1234);
    set_arg(1'b1, 16'hABCD);
    chk("R3 full arg", card_arg_o, 32'hABCD_1234);

    // R1: disabled write ignored
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_word_i = 16'h0105;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    chk("R1 disabled no req", card_req_o, 1'b0);
    chk("R1 disabled last", last_cmd_o, 16'h0);
    chk("R1 disabled pending", cmd_pending_o, 1'b0);
    enable_i = 1'b1;
    irq_mask_i = 16'h4081;

    d = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    issue(16'h0005, 1'b0); respond(5'd16, d);          // R8 type 0 stores nothing
    issue(16'h0202, 1'b0); respond(5'd15, d);          // R4 long short by one
    issue(16'h0202, 1'b0); respond(5'd16, d);          // R8 long stored
    issue(16'h010C, 1'b0); respond(5'd4, 128'h0800_0000); // R5 auth bit masked off, R9 stop
    issue(16'h010C, 1'b1); respond(5'd4, 128'h0800_0000); // R5 auth bit counts
    issue(16'h0911, 1'b1); respond(5'd4, 128'h0800_0000); // R5 busy variant
    issue(16'h0329, 1'b0); respond(5'd4, 128'h0000_0080); // R6 bit31 set
    issue(16'h0329, 1'b0); respond(5'd4, 128'h0000_0000); // R6 bit31 clear
    issue(16'h0603, 1'b0); respond(5'd4, 128'h0020_0000); // R7 hit
    issue(16'h0603, 1'b0); respond(5'd4, 128'h0000_FFFF); // R7 bytes 0,1 ignored
    issue(16'h0107, 1'b0); respond(5'd3, d);              // R4 short type 1
    issue(16'h0704, 1'b0); respond(5'd1, d);              // R4 unchecked type

    // R1: write while outstanding is dropped
    issue(16'h0108, 1'b0);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_word_i = 16'h0233;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    chk("R1 pending no req", card_req_o, 1'b0);
    chk("R1 pending last", last_cmd_o, 16'h0108);
    respond(5'd4, 128'h0);

    clear_stat(16'h0001);
    irq_mask_i = 16'h0000;
    @(negedge clk_i);
    chk("R12 masked irq", irq_o, 1'b0);

    issue(16'hB112, 1'b0); respond(5'd4, 128'h0);         // R10 data read
    issue(16'h0113, 1'b0); respond(5'd4, 128'h0);         // R10 non-data clears

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      logic [2:0] rts [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd4, 3'd5, 3'd7};
      logic [4:0] ln;
      w = 16'($urandom);
      w[10:8] = rts[$urandom_range(0, 7)];
      if ($urandom_range(0, 4) == 0) w[5:0] = 6'd12;
      ln = 5'($urandom_range(0, 16));
      d = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) == 0) d[7:0] = d[7:0] & 8'h02;
      if ($urandom_range(0, 3) == 0) irq_mask_i = 16'($urandom);
      if ($urandom_range(0, 5) == 0) set_arg($urandom_range(0, 1) == 1, 16'($urandom));
      if ($urandom_range(0, 3) == 0) clear_stat(16'($urandom));
      issue(w, $urandom_range(0, 1) == 1);
      respond(ln, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule